// File: doc/BRIEF.md
# Return-From-Trap Control Unit

This unit decides what happens when a return-from-trap instruction reaches execution. From the current program counter, one instruction bit that picks the debug return path, the present status bits (supervisor, previous-supervisor, exception-enable), the debug-mode flag and the saved return state, it produces the next program counter. It also produces a status-register update, a debug-mode clear and three fault pulses: halt, privileged-instruction fault and illegal-instruction fault.

The decision is made combinationally in one cycle and captured in output registers. Results therefore appear on the clock edge after the instruction is presented with its valid bit. The checks follow a fixed order. A cleared supervisor bit is tested first. A set exception-enable bit is tested second. Only then does the unit compare the running mode against the debug-field bit to choose the normal or the debug return. A trap return that fails every check falls through to the sequential address.

Top module: `rett_ctrl`

## Requirements
- R1: After synchronous reset the result-valid flag, every pulse, the write enable, the debug clear, the next PC and the status bits are all 0.
- R2: With the supervisor bit 0, the privileged-fault pulse is 1, the next PC is PC+4 and the status write enable stays 0.
- R3: With the supervisor bit 0, halt is 1 exactly when exception-enable is also 0.
- R4: With supervisor 1 and exception-enable 1, illegal-instruction and halt are both 1, the next PC is PC+4 and the write enable stays 0.
- R5: With supervisor 1, exception-enable 0, debug mode 0 and debug field 0, the next PC is the saved normal PC. The write enable is 1, the new exception-enable is 1, the new supervisor equals the current previous-supervisor bit, and previous-supervisor passes through unchanged.
- R6: With supervisor 1, exception-enable 0, debug mode 1 and debug field 1, the next PC is the saved debug PC. The write enable is 1, the new supervisor and exception-enable take the saved debug copies, and the debug clear is 1.
- R7: With supervisor 1, exception-enable 0 and a debug mode that differs from the debug field, the next PC is PC+4. No pulse, write enable or debug clear is raised, and the status bits pass through.
- R8: At most one of privileged fault, illegal instruction and status write is 1. The supervisor check wins over every other check, and the exception-enable check wins over a matching return path.
- R9: While the instruction-valid input is 0, no pulse, write enable or debug clear is raised on the following cycle, and result-valid is 0.
- R10: PC+4 wraps modulo 2^32, so 0xFFFFFFFC steps to 0x00000000.
- R11: Every output reflects the inputs sampled on the previous rising edge. Result-valid is 1 in the cycle after each valid instruction, and back-to-back instructions give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid_i | input | 1 | A trap-return instruction is presented this cycle |
| pc_i | input | 32 | Address of the instruction |
| dbg_field_i | input | 1 | Instruction bit choosing the debug return path |
| cur_s_i | input | 1 | Current supervisor bit |
| cur_ps_i | input | 1 | Current previous-supervisor bit |
| cur_et_i | input | 1 | Current exception-enable bit |
| dbg_mode_i | input | 1 | Core is in debug mode |
| saved_pc_i | input | 32 | Saved return address for normal traps |
| saved_dbg_pc_i | input | 32 | Saved return address for debug entry |
| saved_dbg_s_i | input | 1 | Saved supervisor copy for debug entry |
| saved_dbg_et_i | input | 1 | Saved exception-enable copy for debug entry |
| res_valid_o | output | 1 | Outputs hold a fresh result |
| next_pc_o | output | 32 | Next program counter |
| stat_we_o | output | 1 | Status-register write pulse |
| new_s_o | output | 1 | New supervisor bit |
| new_ps_o | output | 1 | New previous-supervisor bit |
| new_et_o | output | 1 | New exception-enable bit |
| dbg_clr_o | output | 1 | Pulse that leaves debug mode |
| halt_o | output | 1 | Halt pulse |
| priv_fault_o | output | 1 | Privileged-instruction fault pulse |
| illegal_o | output | 1 | Illegal-instruction fault pulse |

## Verification
The bench goes after the ordering of the checks. It sets supervisor 0 and supervisor-with-enable while the mode and field also match a return path. A design that tested the return paths first would write status and jump to a saved PC instead of faulting. It drives both mismatched mode and field pairs, where a design decoding only one of the two bits would take a return it must refuse. It checks the halt split between the two supervisor-0 cases, the pass-through of the previous-supervisor bit, and a PC at the top of the address space, where a wrong adder width would not wrap to zero. It also holds valid low with fault-provoking inputs, which catches pulses that are not qualified by valid.

// File: rtl/rett_pkg.sv
package rett_pkg;

    typedef struct packed {
        logic s;
        logic ps;
        logic et;
    } rett_stat_t;

    typedef enum logic [2:0] {
        RD_PRIV    = 3'd0,
        RD_ILLEGAL = 3'd1,
        RD_NORMAL  = 3'd2,
        RD_DEBUG   = 3'd3,
        RD_SKIP    = 3'd4
    } rett_dec_t;

    // Ordered checks: supervisor, then enable, then mode/field match.
    function automatic rett_dec_t rett_decide(input rett_stat_t st,
                                              input logic dbg_mode,
                                              input logic dfield);
        rett_dec_t d;
        if (!st.s)
            d = RD_PRIV;
        else if (st.et)
            d = RD_ILLEGAL;
        else if (!dbg_mode && !dfield)
            d = RD_NORMAL;
        else if (dbg_mode && dfield)
            d = RD_DEBUG;
        else
            d = RD_SKIP;
        return d;
    endfunction

endpackage

// File: rtl/rett_classify.sv
module rett_classify
    import rett_pkg::*;
(
    input  rett_stat_t cur_stat,
    input  logic       dbg_mode,
    input  logic       dfield,
    output rett_dec_t  dec,
    output logic       halt_req
);
    always_comb begin
        dec      = rett_decide(cur_stat, dbg_mode, dfield);
        halt_req = (dec == RD_ILLEGAL) || ((dec == RD_PRIV) && !cur_stat.et);
    end
endmodule

// File: rtl/rett_pc_select.sv
module rett_pc_select
    import rett_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  rett_dec_t         dec,
    input  logic [PC_W-1:0]   pc,
    input  logic [PC_W-1:0]   saved_pc,
    input  logic [PC_W-1:0]   saved_dbg_pc,
    output logic [PC_W-1:0]   next_pc
);
    localparam logic [PC_W-1:0] INSN_STEP = PC_W'(4);

    logic [PC_W-1:0] seq_pc;

    always_comb begin
        seq_pc = pc + INSN_STEP;
        unique case (dec)
            RD_NORMAL: next_pc = saved_pc;
            RD_DEBUG:  next_pc = saved_dbg_pc;
            default:   next_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/rett_stat_update.sv
module rett_stat_update
    import rett_pkg::*;
(
    input  rett_dec_t  dec,
    input  rett_stat_t cur_stat,
    input  logic       dbg_s,
    input  logic       dbg_et,
    output rett_stat_t new_stat,
    output logic       we,
    output logic       dbg_clr
);
    always_comb begin
        new_stat = cur_stat;
        we       = 1'b0;
        dbg_clr  = 1'b0;
        unique case (dec)
            RD_NORMAL: begin
                new_stat.s  = cur_stat.ps;
                new_stat.et = 1'b1;
                we          = 1'b1;
            end
            RD_DEBUG: begin
                new_stat.s  = dbg_s;
                new_stat.et = dbg_et;
                we          = 1'b1;
                dbg_clr     = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rett_ctrl.sv
module rett_ctrl
    import rett_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            insn_valid_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic            dbg_field_i,
    input  logic            cur_s_i,
    input  logic            cur_ps_i,
    input  logic            cur_et_i,
    input  logic            dbg_mode_i,
    input  logic [PC_W-1:0] saved_pc_i,
    input  logic [PC_W-1:0] saved_dbg_pc_i,
    input  logic            saved_dbg_s_i,
    input  logic            saved_dbg_et_i,
    output logic            res_valid_o,
    output logic [PC_W-1:0] next_pc_o,
    output logic            stat_we_o,
    output logic            new_s_o,
    output logic            new_ps_o,
    output logic            new_et_o,
    output logic            dbg_clr_o,
    output logic            halt_o,
    output logic            priv_fault_o,
    output logic            illegal_o
);
    rett_stat_t      cur_stat;
    rett_stat_t      nxt_stat;
    rett_stat_t      stat_q;
    rett_dec_t       dec;
    logic            halt_req;
    logic            we_c;
    logic            clr_c;
    logic [PC_W-1:0] nxt_pc;

    assign cur_stat = '{s: cur_s_i, ps: cur_ps_i, et: cur_et_i};

    rett_classify u_classify (
        .cur_stat (cur_stat),
        .dbg_mode (dbg_mode_i),
        .dfield   (dbg_field_i),
        .dec      (dec),
        .halt_req (halt_req)
    );

    rett_pc_select #(.PC_W(PC_W)) u_pc_select (
        .dec          (dec),
        .pc           (pc_i),
        .saved_pc     (saved_pc_i),
        .saved_dbg_pc (saved_dbg_pc_i),
        .next_pc      (nxt_pc)
    );

    rett_stat_update u_stat_update (
        .dec      (dec),
        .cur_stat (cur_stat),
        .dbg_s    (saved_dbg_s_i),
        .dbg_et   (saved_dbg_et_i),
        .new_stat (nxt_stat),
        .we       (we_c),
        .dbg_clr  (clr_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid_o  <= 1'b0;
            next_pc_o    <= '0;
            stat_q       <= '0;
            stat_we_o    <= 1'b0;
            dbg_clr_o    <= 1'b0;
            halt_o       <= 1'b0;
            priv_fault_o <= 1'b0;
            illegal_o    <= 1'b0;
        end else begin
            res_valid_o  <= insn_valid_i;
            stat_we_o    <= insn_valid_i && we_c;
            dbg_clr_o    <= insn_valid_i && clr_c;
            halt_o       <= insn_valid_i && halt_req;
            priv_fault_o <= insn_valid_i && (dec == RD_PRIV);
            illegal_o    <= insn_valid_i && (dec == RD_ILLEGAL);
            if (insn_valid_i) begin
                next_pc_o <= nxt_pc;
                stat_q    <= nxt_stat;
            end
        end
    end

    assign new_s_o  = stat_q.s;
    assign new_ps_o = stat_q.ps;
    assign new_et_o = stat_q.et;

endmodule

// File: rtl/rett_ctrl_chk.sv
module rett_ctrl_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            insn_valid_i,
    input logic [PC_W-1:0] pc_i,
    input logic            dbg_field_i,
    input logic            cur_s_i,
    input logic            cur_et_i,
    input logic            dbg_mode_i,
    input logic            res_valid_o,
    input logic [PC_W-1:0] next_pc_o,
    input logic            stat_we_o,
    input logic            new_et_o,
    input logic            dbg_clr_o,
    input logic            halt_o,
    input logic            priv_fault_o,
    input logic            illegal_o
);
    localparam logic [PC_W-1:0] CHK_STEP = PC_W'(4);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !res_valid_o |-> !(stat_we_o || dbg_clr_o || halt_o || priv_fault_o || illegal_o)); // R9
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        insn_valid_i |=> res_valid_o); // R11
    AST_ILLEGAL_HALTS: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> halt_o); // R4
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({priv_fault_o, illegal_o, stat_we_o})); // R8
    AST_CLR_WITH_WE: assert property (@(posedge clk) disable iff (rst)
        dbg_clr_o |-> stat_we_o); // R6
    AST_PRIV_STEP: assert property (@(posedge clk) disable iff (rst)
        (insn_valid_i && !cur_s_i) |=> (priv_fault_o && next_pc_o == $past(pc_i) + CHK_STEP)); // R2
    AST_NORMAL_RET: assert property (@(posedge clk) disable iff (rst)
        (insn_valid_i && cur_s_i && !cur_et_i && !dbg_mode_i && !dbg_field_i)
        |=> (stat_we_o && new_et_o && !dbg_clr_o)); // R5
endmodule

bind rett_ctrl rett_ctrl_chk #(.PC_W(PC_W)) u_rett_chk (.*);

// File: tb/test_rett_ctrl.sv
module test_rett_ctrl;
    localparam int  PC_W     = 32;
    localparam time CLK_PER  = 10ns;
    localparam int  WDOG_CYC = 5000;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic we, s, ps, et, clr, halt, priv, ill;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            insn_valid_i = 1'b0;
    logic [PC_W-1:0] pc_i = '0;
    logic            dbg_field_i = 1'b0;
    logic            cur_s_i = 1'b0, cur_ps_i = 1'b0, cur_et_i = 1'b0;
    logic            dbg_mode_i = 1'b0;
    logic [PC_W-1:0] saved_pc_i = '0, saved_dbg_pc_i = '0;
    logic            saved_dbg_s_i = 1'b0, saved_dbg_et_i = 1'b0;
    logic            res_valid_o;
    logic [PC_W-1:0] next_pc_o;
    logic            stat_we_o, new_s_o, new_ps_o, new_et_o;
    logic            dbg_clr_o, halt_o, priv_fault_o, illegal_o;

    int   n_checks = 0;
    int   n_fails  = 0;
    logic mon_on   = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #(CLK_PER/2) clk = ~clk;

    rett_ctrl #(.PC_W(PC_W)) i_rett_ctrl (.*);

    task automatic check(input string tag, input string what,
                         input logic [PC_W-1:0] act, input logic [PC_W-1:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // Spec model written from the requirements.
    function automatic exp_t model(input logic [PC_W-1:0] pc, input logic fld,
                                   input logic s, input logic ps, input logic et,
                                   input logic md, input logic [PC_W-1:0] spc,
                                   input logic [PC_W-1:0] dpc, input logic ds, input logic de);
        exp_t e;
        e = '0;
        e.pc = pc + PC_W'(4);
        e.s = s; e.ps = ps; e.et = et;
        if (!s) begin
            e.priv = 1'b1; e.halt = !et;
        end else if (et) begin
            e.ill = 1'b1; e.halt = 1'b1;
        end else if (!md && !fld) begin
            e.pc = spc; e.we = 1'b1; e.s = ps; e.et = 1'b1;
        end else if (md && fld) begin
            e.pc = dpc; e.we = 1'b1; e.s = ds; e.et = de; e.clr = 1'b1;
        end
        return e;
    endfunction

    task automatic issue(input string tag, input logic [PC_W-1:0] pc, input logic fld,
                         input logic s, input logic ps, input logic et, input logic md,
                         input logic [PC_W-1:0] spc, input logic [PC_W-1:0] dpc,
                         input logic ds, input logic de);
        @(negedge clk);
        insn_valid_i = 1'b1; pc_i = pc; dbg_field_i = fld;
        cur_s_i = s; cur_ps_i = ps; cur_et_i = et; dbg_mode_i = md;
        saved_pc_i = spc; saved_dbg_pc_i = dpc; saved_dbg_s_i = ds; saved_dbg_et_i = de;
        exp_q.push_back(model(pc, fld, s, ps, et, md, spc, dpc, ds, de));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            insn_valid_i = 1'b0;
        end
    endtask

    // Monitor: compares each result against the scoreboard.
    always @(negedge clk) begin
        if (mon_on) begin
            if (res_valid_o) begin
                if (exp_q.size() == 0) begin
                    n_checks++; n_fails++;
                    $display("FAIL R11 unexpected result: actual 1 expected 0");
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, "next_pc", next_pc_o, e.pc);
                    check(t, "flags", PC_W'({stat_we_o, new_s_o, new_ps_o, new_et_o,
                                             dbg_clr_o, halt_o, priv_fault_o, illegal_o}),
                          PC_W'({e.we, e.s, e.ps, e.et, e.clr, e.halt, e.priv, e.ill}));
                end
            end else begin
                check("R9", "idle pulses",
                      PC_W'({stat_we_o, dbg_clr_o, halt_o, priv_fault_o, illegal_o}), '0);
            end
        end
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "reset valid", PC_W'(res_valid_o), '0);
        check("R1", "reset pc", next_pc_o, '0);
        check("R1", "reset flags", PC_W'({stat_we_o, new_s_o, new_ps_o, new_et_o,
                                          dbg_clr_o, halt_o, priv_fault_o, illegal_o}), '0);
        mon_on = 1'b1;

        // R2 R3 R8: supervisor 0, with and without enable, matching return path present
        issue("R3", 32'h0000_1000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_2000, 32'h0000_3000, 1'b1, 1'b1);
        issue("R2", 32'h0000_1004, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_2000, 32'h0000_3000, 1'b1, 1'b1);
        issue("R8", 32'h0000_1008, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_2000, 32'h0000_3000, 1'b1, 1'b0);
        // R4 R8: supervisor and enable both set, return paths matching
        issue("R4", 32'h0000_4000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_2000, 32'h0000_3000, 1'b0, 1'b0);
        issue("R8", 32'h0000_4004, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_2000, 32'h0000_3000, 1'b0, 1'b0);
        idle(2);
        // R5: normal return, both previous-supervisor values
        issue("R5", 32'h0000_5000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'hCAFE_0010, 32'h0000_3000, 1'b1, 1'b1);
        issue("R5", 32'h0000_5004, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'hCAFE_0020, 32'h0000_3000, 1'b0, 1'b0);
        // R6: debug return with different saved copies
        issue("R6", 32'h0000_6000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_2000, 32'hBEEF_0040, 1'b0, 1'b1);
        issue("R6", 32'h0000_6004, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_2000, 32'hBEEF_0080, 1'b1, 1'b0);
        // R7: both mismatched pairs
        issue("R7", 32'h0000_7000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_2000, 32'h0000_3000, 1'b1, 1'b1);
        issue("R7", 32'h0000_7004, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_2000, 32'h0000_3000, 1'b1, 1'b1);
        // R10: wrap at top of address space
        issue("R10", 32'hFFFF_FFFC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_2000, 32'h0000_3000, 1'b0, 1'b0);
        issue("R10", 32'hFFFF_FFFC, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_2000, 32'h0000_3000, 1'b0, 1'b0);
        // R9: valid low with fault-provoking inputs, then R11 back-to-back
        @(negedge clk);
        insn_valid_i = 1'b0; cur_s_i = 1'b0; cur_et_i = 1'b0; dbg_mode_i = 1'b1; dbg_field_i = 1'b1;
        idle(3);
        for (int k = 0; k < 8; k++)
            issue("R11", PC_W'(32'h0000_8000 + 4 * k), k[0], k[1], k[2], k[1] & k[2], k[0],
                  PC_W'(32'h0001_0000 + k), PC_W'(32'h0002_0000 + k), k[2], k[0]);
        idle(3);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fails++;
            $display("FAIL R11 missing results: actual %0d expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule